// File: doc/BRIEF.md
# Five-Pin Bidirectional I/O Port with Peripheral Direction Override

This block is a small memory-mapped general-purpose I/O port with five pins. Software sets each pin's direction and output value through three 8-bit registers on a simple read/write bus: a direction register, an output latch register and a pin register. Reading the pin register returns the live pin levels after a two-flop synchronizer. Its three upper bits hold stored control values that drive weak pull-up enables for three other ports.

On-chip peripherals can take over any pin without software knowing. A per-pin output override makes the pin an output and supplies its data. A per-pin input override makes the pin an input. Neither override is ever written into the direction register, so software can safely read, modify and write that register while a peripheral owns a pin. The pad-side outputs are registered. Read data is registered one cycle after the address is presented.

Register select on `bus_addr`: 0 = pin register, 1 = latch register, 2 = direction register, 3 = unmapped.

Top module: `gpio5_port`

## Requirements
- R1: After reset the direction register reads 0x1F (all pins inputs), the latch reads 0x00, the pull-up controls are 0 and `pad_oe` is 0.
- R2: A direction bit of 1 makes its pin an input and 0 makes it an output. With no override, `pad_oe` equals the inverted direction bits one clock after the direction register changes. For example, writing 0x04 gives `pad_oe` = 0x1B.
- R3: A write to the latch register (address 1) sets the latch from data bits 4:0, and `pad_out` follows it one clock later on pins without an output override. Reading the latch register returns the latch contents, not the pin levels.
- R4: A write to the pin register (address 0) loads data bits 4:0 into the latch and data bits 7:5 into the pull-up controls. Writing 0 to either the pin register or the latch register clears the latch. A latch-register write leaves the pull-up controls unchanged.
- R5: Reading the pin register returns the pull-up controls in bits 7:5 and the synchronized pin levels in bits 4:0. A pin change first appears in `bus_rdata` three clock edges after it is applied.
- R6: Bits 7:5 of the direction and latch registers read as 0, and writes to those bits are ignored.
- R7: While `ovr_out_en[i]` is 1, one clock later `pad_oe[i]` is 1 and `pad_out[i]` equals `ovr_dout[i]`. The direction register still reads back the value software last wrote.
- R8: While `ovr_in_en[i]` is 1 and `ovr_out_en[i]` is 0, `pad_oe[i]` is 0 one clock later. If both overrides are active on a pin, the output override wins.
- R9: `pu_en[2:0]` equals the stored pin-register bits 7:5 and changes only on a pin-register write.
- R10: `bus_rdata` shows the register selected by `bus_addr` one clock earlier. Address 3 reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ovr_out_en | input | 5 | Per-pin peripheral force-output |
| ovr_in_en | input | 5 | Per-pin peripheral force-input |
| ovr_dout | input | 5 | Peripheral output data for forced-output pins |
| pad_in | input | 5 | Pin levels from the pads (asynchronous) |
| pad_oe | output | 5 | Pad output enable, 1 = drive |
| pad_out | output | 5 | Pad output data |
| pu_en | output | 3 | Weak pull-up enables for three other ports |

## Verification
The assertions assume that the override inputs and the bus signals are synchronous to `clk`. This lets a one-cycle `$past` of them stand for the values the registered pad logic captured. `pad_in` is the only input that may change freely, and no property depends on it. The bench changes all synchronous inputs only on the falling edge. It changes `pad_in` at arbitrary falling edges and then waits out the synchronizer delay before it expects the new level.

// File: rtl/gpio5_pkg.sv
package gpio5_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_PINS  = 2'd0,
    REG_LATCH = 2'd1,
    REG_DIR   = 2'd2,
    REG_SPARE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio5_sync.sv
module gpio5_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio5_regs.sv
module gpio5_regs
  import gpio5_pkg::*;
#(
  parameter int NPIN = 5,
  parameter int NPU  = 3,
  localparam int DW  = NPIN + NPU
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [NPIN-1:0]   pin_sync,
  output logic [NPIN-1:0]   dir_q,
  output logic [NPIN-1:0]   lat_q,
  output logic [NPU-1:0]    pu_q,
  output logic [DW-1:0]     rdata
);
  reg_sel_e     sel;
  logic [DW-1:0] rd_mux;

  assign sel = reg_sel_e'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '1;
      lat_q <= '0;
      pu_q  <= '0;
    end else if (wr) begin
      case (sel)
        REG_PINS: begin
          lat_q <= wdata[NPIN-1:0];
          pu_q  <= wdata[DW-1:NPIN];
        end
        REG_LATCH: lat_q <= wdata[NPIN-1:0];
        REG_DIR:   dir_q <= wdata[NPIN-1:0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      REG_PINS:  rd_mux = {pu_q, pin_sync};
      REG_LATCH: rd_mux = {{NPU{1'b0}}, lat_q};
      REG_DIR:   rd_mux = {{NPU{1'b0}}, dir_q};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio5_pad_mux.sv
module gpio5_pad_mux #(
  parameter int NPIN = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] dir_q,
  input  logic [NPIN-1:0] lat_q,
  input  logic [NPIN-1:0] ovr_out_en,
  input  logic [NPIN-1:0] ovr_in_en,
  input  logic [NPIN-1:0] ovr_dout,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_out
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic oe_d;
    logic out_d;

    always_comb begin
      if (ovr_out_en[i]) begin
        oe_d  = 1'b1;
        out_d = ovr_dout[i];
      end else if (ovr_in_en[i]) begin
        oe_d  = 1'b0;
        out_d = lat_q[i];
      end else begin
        oe_d  = ~dir_q[i];
        out_d = lat_q[i];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_oe[i]  <= 1'b0;
        pad_out[i] <= 1'b0;
      end else begin
        pad_oe[i]  <= oe_d;
        pad_out[i] <= out_d;
      end
    end
  end
endmodule

// File: rtl/gpio5_port.sv
module gpio5_port #(
  parameter int NPIN        = 5,
  parameter int NPU         = 3,
  parameter int SYNC_STAGES = 2,
  localparam int DW         = NPIN + NPU
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic [1:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NPIN-1:0] ovr_out_en,
  input  logic [NPIN-1:0] ovr_in_en,
  input  logic [NPIN-1:0] ovr_dout,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_out,
  output logic [NPU-1:0]  pu_en
);
  logic [NPIN-1:0] pin_sync;
  logic [NPIN-1:0] dir_q;
  logic [NPIN-1:0] lat_q;
  logic [NPU-1:0]  pu_q;

  gpio5_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (pad_in),
    .q_sync  (pin_sync)
  );

  gpio5_regs #(.NPIN(NPIN), .NPU(NPU)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .pin_sync (pin_sync),
    .dir_q    (dir_q),
    .lat_q    (lat_q),
    .pu_q     (pu_q),
    .rdata    (bus_rdata)
  );

  gpio5_pad_mux #(.NPIN(NPIN)) u_pads (
    .clk        (clk),
    .rst        (rst),
    .dir_q      (dir_q),
    .lat_q      (lat_q),
    .ovr_out_en (ovr_out_en),
    .ovr_in_en  (ovr_in_en),
    .ovr_dout   (ovr_dout),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out)
  );

  assign pu_en = pu_q;
endmodule

// File: rtl/gpio5_port_chk.sv
module gpio5_port_chk #(
  parameter int NPIN = 5,
  parameter int NPU  = 3,
  localparam int DW  = NPIN + NPU
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_wr,
  input logic [1:0]      bus_addr,
  input logic [DW-1:0]   bus_rdata,
  input logic [NPIN-1:0] ovr_out_en,
  input logic [NPIN-1:0] ovr_in_en,
  input logic [NPIN-1:0] ovr_dout,
  input logic [NPIN-1:0] pad_oe,
  input logic [NPIN-1:0] pad_out,
  input logic [NPU-1:0]  pu_en,
  input logic [NPIN-1:0] dir_q
);
  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pad_oe ^ ~$past(dir_q)) & ~($past(ovr_out_en) | $past(ovr_in_en))) == '0)); // R2

  AST_OUT_OVR_DRIVES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe & $past(ovr_out_en)) == $past(ovr_out_en))); // R7

  AST_OUT_OVR_DATA: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pad_out ^ $past(ovr_dout)) & $past(ovr_out_en)) == '0)); // R7

  AST_IN_OVR_RELEASES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe & $past(ovr_in_en) & ~$past(ovr_out_en)) == '0)); // R8

  AST_PU_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == 2'd0) |=> $stable(pu_en)); // R9

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) != 2'd0) |-> (bus_rdata[DW-1:NPIN] == '0)); // R6
endmodule

bind gpio5_port gpio5_port_chk #(.NPIN(NPIN), .NPU(NPU)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .ovr_out_en (ovr_out_en),
  .ovr_in_en  (ovr_in_en),
  .ovr_dout   (ovr_dout),
  .pad_oe     (pad_oe),
  .pad_out    (pad_out),
  .pu_en      (pu_en),
  .dir_q      (dir_q)
);

// File: tb/test_gpio5_port.sv
module test_gpio5_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [4:0] ovr_out_en = 5'h00;
  logic [4:0] ovr_in_en = 5'h00;
  logic [4:0] ovr_dout = 5'h00;
  logic [4:0] pad_in = 5'h00;
  logic [4:0] pad_oe;
  logic [4:0] pad_out;
  logic [2:0] pu_en;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  localparam logic [1:0] A_PINS = 2'd0, A_LAT = 2'd1, A_DIR = 2'd2, A_NONE = 2'd3;
  localparam int K_RD = 0, K_OE = 1, K_OUT = 2, K_PU = 3;

  int         q_due[$];
  int         q_kind[$];
  logic [7:0] q_val[$];
  string      q_tag[$];

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  gpio5_port i_gpio5_port (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ovr_out_en(ovr_out_en), .ovr_in_en(ovr_in_en), .ovr_dout(ovr_dout),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pu_en(pu_en)
  );

  // monitor: pops expected items when due and compares
  always @(negedge clk) begin
    while (q_due.size() > 0 && q_due[0] == cyc) begin
      logic [7:0] act;
      case (q_kind[0])
        K_RD:    act = bus_rdata;
        K_OE:    act = {3'b000, pad_oe};
        K_OUT:   act = {3'b000, pad_out};
        default: act = {5'b00000, pu_en};
      endcase
      checks++;
      if (act !== q_val[0]) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", q_tag[0], act, q_val[0]);
      end
      void'(q_due.pop_front());
      void'(q_kind.pop_front());
      void'(q_val.pop_front());
      void'(q_tag.pop_front());
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int due, input int kind, input logic [7:0] v, input string tag);
    q_due.push_back(due);
    q_kind.push_back(kind);
    q_val.push_back(v);
    q_tag.push_back(tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1;
    bus_addr = a;
    bus_wdata = d;
    tick(1);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a;
    push(cyc + 1, K_RD, exp, tag);
    tick(1);
  endtask

  task automatic chk(input int kind, input logic [7:0] exp, input string tag);
    push(cyc + 1, kind, exp, tag);
    tick(1);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1..: actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(2);

    // R1 reset state
    rd(A_DIR, 8'h1F, "R1 dir reset");
    rd(A_LAT, 8'h00, "R1 latch reset");
    rd(A_PINS, 8'h00, "R1 pins/pull-up reset");
    chk(K_OE, 8'h00, "R1 pad_oe reset");
    chk(K_PU, 8'h00, "R1 pu_en reset");

    // R2 direction
    wr(A_DIR, 8'h04);
    chk(K_OE, 8'h1B, "R2 pad_oe after dir=04");
    rd(A_DIR, 8'h04, "R2 dir readback");

    // R6 upper bits of dir and latch
    wr(A_DIR, 8'hE4);
    rd(A_DIR, 8'h04, "R6 dir upper bits ignored");
    wr(A_LAT, 8'hF5);
    rd(A_LAT, 8'h15, "R6 latch upper bits ignored");
    chk(K_OUT, 8'h15, "R3 pad_out follows latch");

    // R3 latch read is not the pins
    pad_in = 5'h0A;
    tick(4);
    rd(A_LAT, 8'h15, "R3 latch read not pins");
    rd(A_PINS, 8'h0A, "R5 pins read");

    // R5 synchronizer latency
    bus_addr = A_PINS;
    pad_in = 5'h1F;
    push(cyc + 2, K_RD, 8'h0A, "R5 old level at second edge");
    push(cyc + 3, K_RD, 8'h1F, "R5 new level at third edge");
    tick(4);

    // R4 / R9 pin-register write
    wr(A_PINS, 8'hA3);
    rd(A_LAT, 8'h03, "R4 pin write loads latch");
    chk(K_PU, 8'h05, "R9 pu_en from bits 7:5");
    rd(A_PINS, 8'hBF, "R5 pull-ups and pins");
    wr(A_PINS, 8'h00);
    rd(A_LAT, 8'h00, "R4 pin write 0 clears latch");
    wr(A_PINS, 8'hC7);
    wr(A_LAT, 8'h00);
    rd(A_LAT, 8'h00, "R4 latch write 0 clears latch");
    chk(K_PU, 8'h06, "R4 latch write keeps pull-ups");

    // R7 output override
    wr(A_DIR, 8'h1F);
    ovr_out_en = 5'h11;
    ovr_dout = 5'h10;
    tick(1);
    chk(K_OE, 8'h11, "R7 forced outputs");
    chk(K_OUT, 8'h10, "R7 forced data");
    rd(A_DIR, 8'h1F, "R7 dir unchanged by override");

    // R8 input override and priority
    wr(A_DIR, 8'h00);
    ovr_out_en = 5'h01;
    ovr_in_en = 5'h03;
    tick(1);
    chk(K_OE, 8'h1D, "R8 forced input, output wins");
    rd(A_DIR, 8'h00, "R8 dir unchanged by override");
    ovr_out_en = 5'h00;
    ovr_in_en = 5'h00;
    tick(1);
    chk(K_OE, 8'h1F, "R2 release restores dir");

    // R10 unmapped address
    wr(A_NONE, 8'hFF);
    rd(A_NONE, 8'h00, "R10 unmapped reads 0");
    rd(A_DIR, 8'h00, "R10 unmapped write ignored (dir)");
    rd(A_PINS, 8'hDF, "R10 unmapped write ignored (pins)");

    tick(4);
    if (q_due.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard R10: actual=%0d pending expected=0", q_due.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule